// File: doc/BRIEF.md
# Cartridge Bank-Switching Register Controller

This block sits between an 8-bit console's CPU bus and the cartridge memories. Configuration is indirect. A CPU write in 0x8000-0x9FFF selects one of sixteen command numbers. A later write in 0xA000-0xBFFF carries the value for that command. The stored values are eight 1K character-memory bank numbers, three switchable 8K program-ROM bank numbers, one 8K bank number for the 0x6000-0x7FFF window, a RAM/ROM choice for that window, and a nametable mirroring mode.

On every clock the block translates the current CPU address into a program-memory address and the current PPU address into a character-memory address. Each translated address is the bank number followed by the in-window offset, trimmed to the parameterised memory size. The block also gives the nametable A10 select, a RAM-select flag for the low window, and a registered write enable and write data for program RAM. All outputs are registered, so each one reflects the inputs of the previous clock.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After synchronous reset, every bank number is 0, the command number is 0, mirroring is vertical and the 0x6000 window maps to ROM. The 0xE000 window still maps to the last bank.
- R2: A write with cpu_addr in 0x8000-0x9FFF stores cpu_data[3:0] as the command number. cpu_data[7:4] are ignored.
- R3: Command n (0..7), written through 0xA000-0xBFFF, sets the bank of CHR slot n. Slot n covers ppu_addr[12:10] = n. chr_addr is {bank, ppu_addr[9:0]}.
- R4: Command 8 takes cpu_data[7] as the RAM select (1 = RAM, 0 = ROM) and cpu_data[5:0] as the bank for 0x6000-0x7FFF. prg_ram_sel is 1 exactly when the address was in that window and RAM was selected.
- R5: Commands 9, 10 and 11 set the 6-bit banks of the windows at 0x8000, 0xA000 and 0xC000. prg_addr is {bank, cpu_addr[12:0]}.
- R6: CPU addresses in 0xE000-0xFFFF always map to the last 8K bank, whose bank field is all ones.
- R7: Command 12 takes the mirroring mode from cpu_data[1:0]. The modes set ciram_a10 as follows: 00 gives ppu_addr[10], 01 gives ppu_addr[11], 10 gives 0 and 11 gives 1.
- R8: A write in 0x6000-0x7FFF raises prg_ram_we, with prg_ram_wdata set to the data, only while RAM is selected. Otherwise the write is ignored.
- R9: Translated addresses keep only the low PRG_AW or CHR_AW bits, so bank-number bits above the memory size have no effect.
- R10: Every output appears on the clock edge after its inputs are presented. Addresses below 0x6000 give prg_addr 0.
- R11: Commands 13, 14 and 15 change no bank, select or mirroring state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 13 | PPU address bits 12:0 |
| prg_addr | output | PRG_AW | Translated program memory address |
| prg_ram_sel | output | 1 | Access targets program RAM instead of ROM |
| prg_ram_we | output | 1 | Program RAM write enable |
| prg_ram_wdata | output | 8 | Program RAM write data |
| chr_addr | output | CHR_AW | Translated character memory address |
| ciram_a10 | output | 1 | Nametable RAM A10 select |

## Verification
The hardest case to reach from the ports is a stored bank value whose high bits lie above the memory size. Such a value must still leave the unmasked low bits and every other slot intact. The bench builds this with a reduced configuration, 64K program and 8K character memory, and writes bank values with all bits varied. It then sweeps every slot and window at several offsets. Commands 13 to 15 are written afterwards, and the full sweep is repeated to show that nothing moved.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  typedef enum logic [1:0] {
    MIR_VERT = 2'b00,
    MIR_HORZ = 2'b01,
    MIR_LOW  = 2'b10,
    MIR_HIGH = 2'b11
  } mirror_e;

  localparam int CHR_SLOTS   = 8;
  localparam int PRG_SWITCH  = 3;
  localparam int CHR_OFF_W   = 10;
  localparam int PRG_OFF_W   = 13;
  localparam int CHR_FIELD_W = 8;
  localparam int PRG_FIELD_W = 6;

  localparam logic [3:0] CMD_LOW_WIN = 4'd8;
  localparam logic [3:0] CMD_PRG0    = 4'd9;
  localparam logic [3:0] CMD_MIRROR  = 4'd12;

  localparam logic [2:0] WIN_LOW   = 3'd3;
  localparam logic [2:0] WIN_CMD   = 3'd4;
  localparam logic [2:0] WIN_PARAM = 3'd5;
  localparam logic [2:0] WIN_FIXED = 3'd7;
endpackage

// File: rtl/cbc_reg_file.sv
module cbc_reg_file
  import cart_bank_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic [2:0] win,
  input  logic [7:0] data,
  input  logic wr,
  output logic [CHR_SLOTS-1:0][CHR_FIELD_W-1:0] chr_bank,
  output logic [PRG_SWITCH-1:0][PRG_FIELD_W-1:0] prg_bank,
  output logic [PRG_FIELD_W-1:0] low_bank,
  output logic ram_en,
  output mirror_e mirror
);
  logic [3:0] cmd;
  logic cmd_wr;
  logic param_wr;

  assign cmd_wr   = wr && (win == WIN_CMD);
  assign param_wr = wr && (win == WIN_PARAM);

  always_ff @(posedge clk) begin
    if (rst) cmd <= '0;
    else if (cmd_wr) cmd <= data[3:0];
  end

  for (genvar s = 0; s < CHR_SLOTS; s++) begin : g_chr
    always_ff @(posedge clk) begin
      if (rst) chr_bank[s] <= '0;
      else if (param_wr && cmd == 4'(s)) chr_bank[s] <= data;
    end
  end

  for (genvar w = 0; w < PRG_SWITCH; w++) begin : g_prg
    always_ff @(posedge clk) begin
      if (rst) prg_bank[w] <= '0;
      else if (param_wr && cmd == CMD_PRG0 + 4'(w)) prg_bank[w] <= data[PRG_FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_bank <= '0;
      ram_en   <= 1'b0;
      mirror   <= MIR_VERT;
    end else if (param_wr) begin
      if (cmd == CMD_LOW_WIN) begin
        low_bank <= data[PRG_FIELD_W-1:0];
        ram_en   <= data[7];
      end
      if (cmd == CMD_MIRROR) mirror <= mirror_e'(data[1:0]);
    end
  end
endmodule

// File: rtl/cbc_prg_xlate.sv
module cbc_prg_xlate
  import cart_bank_pkg::*;
#(
  parameter int PRG_AW = 19
) (
  input  logic clk,
  input  logic rst,
  input  logic [15:0] cpu_addr,
  input  logic [7:0] cpu_data,
  input  logic cpu_wr,
  input  logic [PRG_SWITCH-1:0][PRG_FIELD_W-1:0] prg_bank,
  input  logic [PRG_FIELD_W-1:0] low_bank,
  input  logic ram_en,
  output logic [PRG_AW-1:0] prg_addr,
  output logic prg_ram_sel,
  output logic prg_ram_we,
  output logic [7:0] prg_ram_wdata
);
  localparam int FULL_W = PRG_FIELD_W + PRG_OFF_W;
  localparam int LAST_W = PRG_AW - PRG_OFF_W;

  logic [2:0] win;
  logic [PRG_FIELD_W-1:0] sel_bank;
  logic [FULL_W-1:0] composed;
  logic [PRG_AW-1:0] addr_d;
  logic in_low;

  assign win    = cpu_addr[15:13];
  assign in_low = (win == WIN_LOW);

  always_comb begin
    sel_bank = low_bank;
    case (win)
      3'd4: sel_bank = prg_bank[0];
      3'd5: sel_bank = prg_bank[1];
      3'd6: sel_bank = prg_bank[2];
      default: sel_bank = low_bank;
    endcase
  end

  assign composed = {sel_bank, cpu_addr[PRG_OFF_W-1:0]};

  always_comb begin
    if (win == WIN_FIXED) addr_d = {{LAST_W{1'b1}}, cpu_addr[PRG_OFF_W-1:0]};
    else if (win < WIN_LOW) addr_d = '0;
    else addr_d = PRG_AW'(composed);
  end

  always_ff @(posedge clk) begin
    prg_addr      <= addr_d;
    prg_ram_wdata <= cpu_data;
    if (rst) begin
      prg_ram_sel <= 1'b0;
      prg_ram_we  <= 1'b0;
    end else begin
      prg_ram_sel <= in_low && ram_en;
      prg_ram_we  <= in_low && ram_en && cpu_wr;
    end
  end
endmodule

// File: rtl/cbc_chr_xlate.sv
module cbc_chr_xlate
  import cart_bank_pkg::*;
#(
  parameter int CHR_AW = 18
) (
  input  logic clk,
  input  logic [12:0] ppu_addr,
  input  logic [CHR_SLOTS-1:0][CHR_FIELD_W-1:0] chr_bank,
  input  mirror_e mirror,
  output logic [CHR_AW-1:0] chr_addr,
  output logic ciram_a10
);
  localparam int FULL_W = CHR_FIELD_W + CHR_OFF_W;

  logic [FULL_W-1:0] composed;
  logic a10_d;

  assign composed = {chr_bank[ppu_addr[12:10]], ppu_addr[CHR_OFF_W-1:0]};

  always_comb begin
    case (mirror)
      MIR_VERT: a10_d = ppu_addr[10];
      MIR_HORZ: a10_d = ppu_addr[11];
      MIR_LOW:  a10_d = 1'b0;
      default:  a10_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    chr_addr  <= CHR_AW'(composed);
    ciram_a10 <= a10_d;
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int PRG_AW = 19,
  parameter int CHR_AW = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic [15:0] cpu_addr,
  input  logic [7:0] cpu_data,
  input  logic cpu_wr,
  input  logic [12:0] ppu_addr,
  output logic [PRG_AW-1:0] prg_addr,
  output logic prg_ram_sel,
  output logic prg_ram_we,
  output logic [7:0] prg_ram_wdata,
  output logic [CHR_AW-1:0] chr_addr,
  output logic ciram_a10
);
  logic [CHR_SLOTS-1:0][CHR_FIELD_W-1:0] chr_bank;
  logic [PRG_SWITCH-1:0][PRG_FIELD_W-1:0] prg_bank;
  logic [PRG_FIELD_W-1:0] low_bank;
  logic ram_en;
  mirror_e mirror;

  cbc_reg_file u_regs (
    .clk(clk), .rst(rst), .win(cpu_addr[15:13]), .data(cpu_data), .wr(cpu_wr),
    .chr_bank(chr_bank), .prg_bank(prg_bank), .low_bank(low_bank),
    .ram_en(ram_en), .mirror(mirror)
  );

  cbc_prg_xlate #(.PRG_AW(PRG_AW)) u_prg (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
    .prg_bank(prg_bank), .low_bank(low_bank), .ram_en(ram_en),
    .prg_addr(prg_addr), .prg_ram_sel(prg_ram_sel), .prg_ram_we(prg_ram_we),
    .prg_ram_wdata(prg_ram_wdata)
  );

  cbc_chr_xlate #(.CHR_AW(CHR_AW)) u_chr (
    .clk(clk), .ppu_addr(ppu_addr), .chr_bank(chr_bank), .mirror(mirror),
    .chr_addr(chr_addr), .ciram_a10(ciram_a10)
  );
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int PRG_AW = 19,
  parameter int CHR_AW = 18
) (
  input logic clk,
  input logic rst,
  input logic [15:0] cpu_addr,
  input logic [7:0] cpu_data,
  input logic cpu_wr,
  input logic [12:0] ppu_addr,
  input logic [PRG_AW-1:0] prg_addr,
  input logic prg_ram_sel,
  input logic prg_ram_we,
  input logic [7:0] prg_ram_wdata,
  input logic [CHR_AW-1:0] chr_addr,
  input logic ciram_a10
);
  localparam int LAST_W = PRG_AW - 13;

  AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    prg_ram_we |-> ($past(cpu_wr) && $past(cpu_addr[15:13]) == 3'd3)); // R8
  AST_WE_WITH_SEL: assert property (@(posedge clk) disable iff (rst)
    prg_ram_we |-> prg_ram_sel); // R4
  AST_WDATA_TRACKS: assert property (@(posedge clk) disable iff (rst)
    prg_ram_we |-> prg_ram_wdata == $past(cpu_data)); // R8
  AST_FIXED_LAST: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_addr[15:13]) == 3'd7) |-> prg_addr[PRG_AW-1:13] == {LAST_W{1'b1}}); // R6
  AST_PRG_OFFSET: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_addr[15:13]) >= 3'd3) |-> prg_addr[12:0] == $past(cpu_addr[12:0])); // R10
  AST_CHR_OFFSET: assert property (@(posedge clk) disable iff (rst)
    chr_addr[9:0] == $past(ppu_addr[9:0])); // R3
  AST_SEL_WINDOW: assert property (@(posedge clk) disable iff (rst)
    prg_ram_sel |-> $past(cpu_addr[15:13]) == 3'd3); // R4
endmodule

bind cart_bank_ctrl cbc_checker #(.PRG_AW(PRG_AW), .CHR_AW(CHR_AW)) u_chk (.*);

// File: tb/test_cart_bank_ctrl.sv
module test_cart_bank_ctrl;
  localparam int PAW = 16;
  localparam int CAW = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_data = '0;
  logic cpu_wr = 1'b0;
  logic [12:0] ppu_addr = '0;
  logic [PAW-1:0] prg_addr;
  logic prg_ram_sel;
  logic prg_ram_we;
  logic [7:0] prg_ram_wdata;
  logic [CAW-1:0] chr_addr;
  logic ciram_a10;

  int checks = 0;
  int fails = 0;

  logic [7:0] m_chr [8];
  logic [5:0] m_prg [4];
  logic m_ram = 1'b0;
  logic [1:0] m_mir = 2'b00;

  always #2.5 clk = ~clk;

  cart_bank_ctrl #(.PRG_AW(PAW), .CHR_AW(CAW)) i_cart_bank_ctrl (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
    .ppu_addr(ppu_addr), .prg_addr(prg_addr), .prg_ram_sel(prg_ram_sel),
    .prg_ram_we(prg_ram_we), .prg_ram_wdata(prg_ram_wdata), .chr_addr(chr_addr),
    .ciram_a10(ciram_a10)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_prg(input logic [15:0] a);
    logic [31:0] bank;
    case (a[15:13])
      3'd3: bank = 32'(m_prg[0]);
      3'd4: bank = 32'(m_prg[1]);
      3'd5: bank = 32'(m_prg[2]);
      3'd6: bank = 32'(m_prg[3]);
      3'd7: bank = 32'hFFFF;
      default: return 32'd0;
    endcase
    return ((bank << 13) | 32'(a[12:0])) & ((32'd1 << PAW) - 1);
  endfunction

  function automatic logic exp_a10(input logic [12:0] p);
    case (m_mir)
      2'd0: return p[10];
      2'd1: return p[11];
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] cmd, input logic [7:0] d);
    cpu_write(16'h8000 | 16'(cmd[0] ? 16'h0123 : 16'h1F00), cmd);
    cpu_write(16'hA000 | 16'(d), d);
  endtask

  task automatic probe_chr(input string tag, input int slot, input int off);
    logic [31:0] e;
    @(negedge clk);
    ppu_addr = 13'((slot << 10) | off);
    @(negedge clk);
    e = ((32'(m_chr[slot]) << 10) | 32'(off)) & ((32'd1 << CAW) - 1);
    chk(tag, 32'(chr_addr), e);
  endtask

  task automatic probe_prg(input string tag, input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b0;
    @(negedge clk);
    chk(tag, 32'(prg_addr), exp_prg(a));
    chk(tag, 32'(prg_ram_sel), 32'(a[15:13] == 3'd3 && m_ram));
  endtask

  task automatic sweep_all(input string tag);
    for (int s = 0; s < 8; s++) begin
      probe_chr(tag, s, 0);
      probe_chr(tag, s, 10'h3FF);
      probe_chr(tag, s, 10'h2A5);
    end
    for (int w = 3; w < 8; w++) begin
      probe_prg(tag, 16'((w << 13) | 13'h0000));
      probe_prg(tag, 16'((w << 13) | 13'h1ABC));
    end
  endtask

  task automatic probe_mirror(input string tag);
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      ppu_addr = 13'(q << 10);
      @(negedge clk);
      chk(tag, 32'(ciram_a10), 32'(exp_a10(13'(q << 10))));
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_chr[i] = '0;
    for (int i = 0; i < 4; i++) m_prg[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    sweep_all("R1 reset map");
    probe_mirror("R1 reset mirroring");
    probe_prg("R1 R10 below window", 16'h4123);

    // R2 R3 R9 CHR slots, command upper bits set
    for (int s = 0; s < 8; s++) begin
      logic [7:0] v;
      v = 8'((s * 53 + 9) & 8'hFF);
      cpu_write(16'h8000 | 16'(s * 16'h0111), 8'hF0 | 8'(s));
      cpu_write(16'hA000, v);
      m_chr[s] = v;
    end
    sweep_all("R2 R3 R9 chr banks");

    // R5 R6 R9 switchable PRG banks
    cpu_write(16'h9FFF, 8'h09); cpu_write(16'hA001, 8'h3D); m_prg[1] = 6'h3D;
    cpu_write(16'h8000, 8'h0A); cpu_write(16'hBFFF, 8'h12); m_prg[2] = 6'h12;
    cpu_write(16'h8000, 8'h0B); cpu_write(16'hA000, 8'hEF); m_prg[3] = 6'h2F;
    sweep_all("R5 R6 R9 prg banks");

    // R4 low window to RAM, R8 writes
    cpu_write(16'h8000, 8'h08); cpu_write(16'hA000, 8'h85); m_prg[0] = 6'h05; m_ram = 1'b1;
    probe_prg("R4 ram window", 16'h6777);
    probe_prg("R4 ram window end", 16'h7FFF);
    @(negedge clk);
    cpu_addr = 16'h6456; cpu_data = 8'hA7; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    chk("R8 we with ram", 32'(prg_ram_we), 32'd1);
    chk("R8 wdata", 32'(prg_ram_wdata), 32'hA7);
    chk("R8 waddr", 32'(prg_addr), exp_prg(16'h6456));
    @(negedge clk);
    chk("R8 we single cycle", 32'(prg_ram_we), 32'd0);

    cpu_write(16'h8000, 8'h08); cpu_write(16'hA000, 8'h43); m_prg[0] = 6'h03; m_ram = 1'b0;
    probe_prg("R4 rom window", 16'h6001);
    @(negedge clk);
    cpu_addr = 16'h7001; cpu_data = 8'h5A; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    chk("R8 write ignored rom", 32'(prg_ram_we), 32'd0);
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_data = 8'h5A; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    chk("R8 no we outside window", 32'(prg_ram_we), 32'd0);

    // R7 mirroring modes
    for (int m = 0; m < 4; m++) begin
      cpu_write(16'h8000, 8'h0C);
      cpu_write(16'hA000, 8'hFC | 8'(m));
      m_mir = 2'(m);
      probe_mirror("R7 mirroring");
    end

    // R11 unused commands
    cpu_write(16'h8000, 8'h08); cpu_write(16'hA000, 8'h81); m_prg[0] = 6'h01; m_ram = 1'b1;
    for (int c = 13; c < 16; c++) begin
      cpu_write(16'h8000, 8'(c));
      cpu_write(16'hA000, 8'h00);
      cpu_write(16'hA000, 8'h7E);
    end
    sweep_all("R11 unused commands");
    probe_mirror("R11 mirroring kept");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule